// File: doc/BRIEF.md
# DDR2/DDR3 Power-Up Initialization Sequencer

This block runs the power-up command script for a DDR2 or DDR3 SDRAM. It starts on a start pulse after a synchronous reset. A static mode input picks the memory type. The block issues one command at a time on a valid/ready command port. Each command carries a command code, an address word and two control flags: one for DLL reset and one for the OCD-default state. The required microsecond pauses are timed with a cycle counter. Its length comes from the clock-frequency parameter.

Extended mode-register commands select register n (n = 1, 2, 3) by placing n at a bank-address bit position. The block works out that position from the column-count field, the row-count field, the address decoding order and the data-bus width. When the script reaches normal mode, the block raises a done flag. In the same step it loads the refresh-rate value into the refresh timer output for one cycle.

Physical signalling, data paths and periodic refresh are handled elsewhere. The sequencer only produces the ordered command stream.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset is sampled high, the block is idle: busy, done, cmd_valid and rfsh_load are all 0.
- R2: A start pulse seen while the block is not busy sets busy in the next cycle and clears done. In that same cycle the first command is valid. Start has no effect while busy is high.
- R3: With ddr3_mode = 0 the command order is: NOP, wait, NOP, PALL, EMRS(2), EMRS(3), EMRS(1), MRS, PALL, REF, REF, MRS, EMRS(1), EMRS(1), NORMAL. The cmd_code values are NOP = 1, PALL = 2, MRS = 3, EMRS = 4, REF = 5, ZQ = 6, NORMAL = 7. When cmd_valid is 0, cmd_code, cmd_addr and both flags are 0.
- R4: With ddr3_mode = 1 the command order is: NOP, wait, NOP, EMRS(2), EMRS(3), EMRS(1), MRS, wait, ZQ, NORMAL. The codes are the same as in R3.
- R5: A valid command keeps its code and address until cmd_ready is seen high at a clock edge. The script moves on only at that handshake. When no wait follows, the next command is valid in the very next cycle.
- R6: Each wait holds cmd_valid low for exactly N+1 cycles, where N = max(1, us × CLK_MHZ). The value of us is PWR2_US for the DDR2 power-up wait, PWR3_US for the DDR3 power-up wait and DLL3_US for the DDR3 wait after MRS.
- R7: For EMRS(n), cmd_addr equals n shifted left by S. S = col_cfg + 9, plus (row_cfg + 11) when seq_decode = 1, plus 1 when bus32 = 1 or 2 when bus32 = 0. All other commands carry cmd_addr = 0.
- R8: cmd_dll_rst is 1 only from the first MRS through the second REF in DDR2, and on the MRS in DDR3. cmd_ocd_dflt is 1 only on the first of the two closing EMRS(1) commands in DDR2.
- R9: The cycle after the NORMAL handshake is idle with busy still high. In the cycle after that, busy falls, done rises and rfsh_load is high for exactly one cycle with rfsh_value = refresh_val. Done then stays high until the next start or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse for the script |
| ddr3_mode | input | 1 | 0 = DDR2 script, 1 = DDR3 script (static) |
| col_cfg | input | 2 | Column-count field |
| row_cfg | input | 2 | Row-count field |
| bus32 | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| seq_decode | input | 1 | 1 = sequential address decoding, 0 = interleaved |
| refresh_val | input | RW | Refresh-rate value loaded at completion |
| cmd_ready | input | 1 | Command accepted by the downstream controller |
| cmd_valid | output | 1 | Command present |
| cmd_code | output | 3 | Command code (see R3) |
| cmd_addr | output | AW | Address word carrying the mode-register select |
| cmd_dll_rst | output | 1 | DLL-reset flag for this command |
| cmd_ocd_dflt | output | 1 | OCD-default flag for this command |
| busy | output | 1 | Script in progress |
| done | output | 1 | Normal mode reached |
| rfsh_load | output | 1 | One-cycle strobe that loads the refresh timer |
| rfsh_value | output | RW | Refresh value to load |

## Verification
The start input can arrive in the same cycle in which a command handshake completes or a wait expires. In that cycle the script must advance as usual and must not restart. The bench drives repeated start pulses throughout both scripts while cmd_ready follows several patterns, so many of these collisions happen at handshakes and at wait expiry. A behavioural queue model predicts every output on every cycle, so a restart or a skipped step shows up as a mismatch. A second collision is a start pulse in the cycle where done rises. That start must be accepted, and the model predicts this case as well.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    C_NONE = 3'd0,
    C_NOP  = 3'd1,
    C_PALL = 3'd2,
    C_MRS  = 3'd3,
    C_EMRS = 3'd4,
    C_REF  = 3'd5,
    C_ZQ   = 3'd6,
    C_NORM = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_WAIT = 2'd1,
    K_END  = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    W_PWR2 = 2'd0,
    W_PWR3 = 2'd1,
    W_DLL3 = 2'd2
  } wsel_e;

  typedef struct packed {
    kind_e      kind;
    cmd_e       code;
    logic [1:0] mr;
    logic       dll;
    logic       ocd;
    wsel_e      wsel;
  } step_t;

  function automatic step_t mk_cmd(cmd_e c, logic [1:0] mr, logic dll, logic ocd);
    step_t s;
    s.kind = K_CMD;
    s.code = c;
    s.mr   = mr;
    s.dll  = dll;
    s.ocd  = ocd;
    s.wsel = W_PWR2;
    return s;
  endfunction

  function automatic step_t mk_wait(wsel_e w);
    step_t s;
    s.kind = K_WAIT;
    s.code = C_NONE;
    s.mr   = 2'd0;
    s.dll  = 1'b0;
    s.ocd  = 1'b0;
    s.wsel = w;
    return s;
  endfunction

  function automatic step_t mk_end();
    step_t s;
    s.kind = K_END;
    s.code = C_NONE;
    s.mr   = 2'd0;
    s.dll  = 1'b0;
    s.ocd  = 1'b0;
    s.wsel = W_PWR2;
    return s;
  endfunction

  // Bit position of the bank select inside the address word.
  function automatic int unsigned bank_shift(logic [1:0] col, logic [1:0] row,
                                             logic seq, logic bus32);
    int unsigned sh;
    sh = 32'(col) + 32'd9;
    if (seq) sh = sh + 32'(row) + 32'd11;
    sh = sh + (bus32 ? 32'd1 : 32'd2);
    return sh;
  endfunction

  // Pause length in cycles, never below one.
  function automatic int unsigned wait_cycles(int unsigned us, int unsigned mhz);
    int unsigned p;
    p = us * mhz;
    return (p == 0) ? 32'd1 : p;
  endfunction

endpackage

// File: rtl/ddr_init_script.sv
module ddr_init_script
  import ddr_init_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic          ddr3_mode,
  input  logic [IW-1:0] idx,
  output step_t         step
);

  always_comb begin
    step = mk_end();
    if (!ddr3_mode) begin
      case (int'(idx))
        0:  step = mk_cmd(C_NOP,  2'd0, 1'b0, 1'b0);
        1:  step = mk_wait(W_PWR2);
        2:  step = mk_cmd(C_NOP,  2'd0, 1'b0, 1'b0);
        3:  step = mk_cmd(C_PALL, 2'd0, 1'b0, 1'b0);
        4:  step = mk_cmd(C_EMRS, 2'd2, 1'b0, 1'b0);
        5:  step = mk_cmd(C_EMRS, 2'd3, 1'b0, 1'b0);
        6:  step = mk_cmd(C_EMRS, 2'd1, 1'b0, 1'b0);
        7:  step = mk_cmd(C_MRS,  2'd0, 1'b1, 1'b0);
        8:  step = mk_cmd(C_PALL, 2'd0, 1'b1, 1'b0);
        9:  step = mk_cmd(C_REF,  2'd0, 1'b1, 1'b0);
        10: step = mk_cmd(C_REF,  2'd0, 1'b1, 1'b0);
        11: step = mk_cmd(C_MRS,  2'd0, 1'b0, 1'b0);
        12: step = mk_cmd(C_EMRS, 2'd1, 1'b0, 1'b1);
        13: step = mk_cmd(C_EMRS, 2'd1, 1'b0, 1'b0);
        14: step = mk_cmd(C_NORM, 2'd0, 1'b0, 1'b0);
        default: step = mk_end();
      endcase
    end else begin
      case (int'(idx))
        0: step = mk_cmd(C_NOP,  2'd0, 1'b0, 1'b0);
        1: step = mk_wait(W_PWR3);
        2: step = mk_cmd(C_NOP,  2'd0, 1'b0, 1'b0);
        3: step = mk_cmd(C_EMRS, 2'd2, 1'b0, 1'b0);
        4: step = mk_cmd(C_EMRS, 2'd3, 1'b0, 1'b0);
        5: step = mk_cmd(C_EMRS, 2'd1, 1'b0, 1'b0);
        6: step = mk_cmd(C_MRS,  2'd0, 1'b1, 1'b0);
        7: step = mk_wait(W_DLL3);
        8: step = mk_cmd(C_ZQ,   2'd0, 1'b0, 1'b0);
        9: step = mk_cmd(C_NORM, 2'd0, 1'b0, 1'b0);
        default: step = mk_end();
      endcase
    end
  end

endmodule

// File: rtl/ddr_bank_geom.sv
module ddr_bank_geom
  import ddr_init_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [1:0]    col_cfg,
  input  logic [1:0]    row_cfg,
  input  logic          seq_decode,
  input  logic          bus32,
  input  logic [1:0]    mr_sel,
  output logic [AW-1:0] addr
);

  localparam int SHW = $clog2(AW);

  logic [SHW-1:0] shift;
  logic [AW-1:0]  sel_wide;

  always_comb begin
    shift    = SHW'(bank_shift(col_cfg, row_cfg, seq_decode, bus32));
    sel_wide = AW'(mr_sel);
    addr     = sel_wide << shift;
  end

endmodule

// File: rtl/ddr_wait_timer.sv
module ddr_wait_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  input  logic          ack,
  output logic          armed,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (load) begin
      armed <= 1'b1;
      cnt   <= len - CW'(1);
    end else if (ack) begin
      armed <= 1'b0;
    end else if (armed && cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign expired = armed && (cnt == '0);

  // R6: a reload never lands on a pause still running
  p_load_unarmed_r6: assert property (@(posedge clk) disable iff (rst)
    load |-> !armed);

  // R6: acknowledged expiry disarms the counter
  p_ack_disarms_r6: assert property (@(posedge clk) disable iff (rst)
    (expired && ack && !load) |=> !armed);

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int CLK_MHZ = 200,
  parameter int PWR2_US = 200,
  parameter int PWR3_US = 500,
  parameter int DLL3_US = 50,
  parameter int AW      = 32,
  parameter int RW      = 16,
  parameter int IW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ddr3_mode,
  input  logic [1:0]    col_cfg,
  input  logic [1:0]    row_cfg,
  input  logic          bus32,
  input  logic          seq_decode,
  input  logic [RW-1:0] refresh_val,
  input  logic          cmd_ready,
  output logic          cmd_valid,
  output logic [2:0]    cmd_code,
  output logic [AW-1:0] cmd_addr,
  output logic          cmd_dll_rst,
  output logic          cmd_ocd_dflt,
  output logic          busy,
  output logic          done,
  output logic          rfsh_load,
  output logic [RW-1:0] rfsh_value
);

  localparam int unsigned N_PWR2 = wait_cycles(PWR2_US, CLK_MHZ);
  localparam int unsigned N_PWR3 = wait_cycles(PWR3_US, CLK_MHZ);
  localparam int unsigned N_DLL3 = wait_cycles(DLL3_US, CLK_MHZ);
  localparam int unsigned N_MAX  = (N_PWR2 > N_PWR3) ?
                                   ((N_PWR2 > N_DLL3) ? N_PWR2 : N_DLL3) :
                                   ((N_PWR3 > N_DLL3) ? N_PWR3 : N_DLL3);
  localparam int CW = $clog2(N_MAX + 1);

  logic          running;
  logic [IW-1:0] idx;
  step_t         step;
  logic [AW-1:0] geom_addr;
  logic [CW-1:0] wait_len;

  // named internal events
  logic is_cmd, is_wait, is_end;
  logic handshake, wait_done, advance, start_take;
  logic tmr_load, tmr_armed, tmr_expired;

  ddr_init_script #(.IW(IW)) u_script (
    .ddr3_mode (ddr3_mode),
    .idx       (idx),
    .step      (step)
  );

  ddr_bank_geom #(.AW(AW)) u_geom (
    .col_cfg    (col_cfg),
    .row_cfg    (row_cfg),
    .seq_decode (seq_decode),
    .bus32      (bus32),
    .mr_sel     (step.mr),
    .addr       (geom_addr)
  );

  always_comb begin
    case (step.wsel)
      W_PWR3:  wait_len = CW'(N_PWR3);
      W_DLL3:  wait_len = CW'(N_DLL3);
      default: wait_len = CW'(N_PWR2);
    endcase
  end

  ddr_wait_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .len     (wait_len),
    .ack     (wait_done),
    .armed   (tmr_armed),
    .expired (tmr_expired)
  );

  assign is_cmd     = running && (step.kind == K_CMD);
  assign is_wait    = running && (step.kind == K_WAIT);
  assign is_end     = running && (step.kind == K_END);
  assign handshake  = is_cmd && cmd_ready;
  assign tmr_load   = is_wait && !tmr_armed;
  assign wait_done  = is_wait && tmr_expired;
  assign advance    = handshake || wait_done;
  assign start_take = !running && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      idx        <= '0;
      done       <= 1'b0;
      rfsh_load  <= 1'b0;
      rfsh_value <= '0;
    end else begin
      rfsh_load <= 1'b0;
      if (start_take) begin
        running <= 1'b1;
        idx     <= '0;
        done    <= 1'b0;
      end else if (is_end) begin
        running    <= 1'b0;
        done       <= 1'b1;
        rfsh_load  <= 1'b1;
        rfsh_value <= refresh_val;
      end else if (advance) begin
        idx <= idx + IW'(1);
      end
    end
  end

  assign busy         = running;
  assign cmd_valid    = is_cmd;
  assign cmd_code     = is_cmd ? step.code : 3'd0;
  assign cmd_addr     = is_cmd ? geom_addr : '0;
  assign cmd_dll_rst  = is_cmd && step.dll;
  assign cmd_ocd_dflt = is_cmd && step.ocd;

  // R5: an unaccepted command holds its contents
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_addr)));

  // R2: a start during a run does not rewind the script
  p_no_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && start && idx != '0) |=> (!busy || idx != '0));

  // R6: no command while a pause is counting
  p_quiet_wait_r6: assert property (@(posedge clk) disable iff (rst)
    tmr_armed |-> !cmd_valid);

  // R9: completion is idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !cmd_valid));

  // R9: refresh load is a single-cycle strobe
  p_load_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rfsh_load |=> !rfsh_load);

  // R9: done rises together with the refresh load
  p_done_load_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> rfsh_load);

  // R7: the address word carries at most a two-bit select
  p_sel_bits_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ($countones(cmd_addr) <= 2));

  // R8: the two flags never appear on the same command
  p_flag_excl_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !(cmd_dll_rst && cmd_ocd_dflt));

endmodule

// File: tb/test_ddr_init_seq.sv
module test_ddr_init_seq;

  localparam int MHZ = 2;
  localparam int P2 = 200, P3 = 500, D3 = 50;
  localparam int AW = 32, RW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          ddr3_mode = 1'b0;
  logic [1:0]    col_cfg = 2'd0, row_cfg = 2'd0;
  logic          bus32 = 1'b0, seq_decode = 1'b0;
  logic [RW-1:0] refresh_val = '0;
  logic          cmd_ready = 1'b0;
  logic          cmd_valid, cmd_dll_rst, cmd_ocd_dflt, busy, done, rfsh_load;
  logic [2:0]    cmd_code;
  logic [AW-1:0] cmd_addr;
  logic [RW-1:0] rfsh_value;

  ddr_init_seq #(.CLK_MHZ(MHZ), .PWR2_US(P2), .PWR3_US(P3), .DLL3_US(D3),
                 .AW(AW), .RW(RW)) i_ddr_init_seq (
    .clk(clk), .rst(rst), .start(start), .ddr3_mode(ddr3_mode),
    .col_cfg(col_cfg), .row_cfg(row_cfg), .bus32(bus32), .seq_decode(seq_decode),
    .refresh_val(refresh_val), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_dll_rst(cmd_dll_rst),
    .cmd_ocd_dflt(cmd_ocd_dflt), .busy(busy), .done(done),
    .rfsh_load(rfsh_load), .rfsh_value(rfsh_value));

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---- behavioural model: queue of pending items ----
  // kind: 0 command, 1 wait, 2 end
  int          qk[$], qc[$], qd[$], qo[$], qw[$];
  logic [31:0] qa[$];
  int  mph = 0;          // 0 idle, 1 running, 2 completion cycle
  bit  mdone = 0, model_ok = 0;
  logic [RW-1:0] mrf = '0;
  bit  rst_req = 1, start_req = 0, noise = 0;
  int  rpat = 0;

  function automatic int sel_pos();
    int rowpart;
    rowpart = seq_decode ? (int'(row_cfg) + 11) : 0;
    return 11 - int'(bus32) + int'(col_cfg) + rowpart;
  endfunction

  task automatic push(int k, int c, int mr, int d, int o, int w);
    qk.push_back(k); qc.push_back(c); qd.push_back(d); qo.push_back(o);
    qw.push_back(w);
    qa.push_back(32'(mr) << sel_pos());
  endtask

  task automatic pop();
    void'(qk.pop_front()); void'(qc.pop_front()); void'(qd.pop_front());
    void'(qo.pop_front()); void'(qw.pop_front()); void'(qa.pop_front());
  endtask

  task automatic build();
    qk.delete(); qc.delete(); qd.delete(); qo.delete(); qw.delete(); qa.delete();
    if (!ddr3_mode) begin
      push(0,1,0,0,0,0); push(1,0,0,0,0, P2*MHZ+1); push(0,1,0,0,0,0);
      push(0,2,0,0,0,0); push(0,4,2,0,0,0); push(0,4,3,0,0,0); push(0,4,1,0,0,0);
      push(0,3,0,1,0,0); push(0,2,0,1,0,0); push(0,5,0,1,0,0); push(0,5,0,1,0,0);
      push(0,3,0,0,0,0); push(0,4,1,0,1,0); push(0,4,1,0,0,0); push(0,7,0,0,0,0);
    end else begin
      push(0,1,0,0,0,0); push(1,0,0,0,0, P3*MHZ+1); push(0,1,0,0,0,0);
      push(0,4,2,0,0,0); push(0,4,3,0,0,0); push(0,4,1,0,0,0);
      push(0,3,0,1,0,0); push(1,0,0,0,0, D3*MHZ+1); push(0,6,0,0,0,0);
      push(0,7,0,0,0,0);
    end
    push(2,0,0,0,0,0);
  endtask

  always @(negedge clk) begin
    bit s, r;
    cyc++;
    if (model_ok) begin
      bit ev;
      int ec, ed, eo;
      logic [31:0] ea;
      ev = (mph == 1) && (qk[0] == 0);
      ec = ev ? qc[0] : 0;
      ea = ev ? qa[0] : 32'd0;
      ed = ev ? qd[0] : 0;
      eo = ev ? qo[0] : 0;
      chk(busy == (mph == 1), "R2 busy", busy, mph == 1);
      if (mph == 1 && qk[0] == 1)
        chk(cmd_valid == 1'b0, "R6 quiet during wait", cmd_valid, 0);
      else
        chk(cmd_valid == ev, "R5 valid", cmd_valid, ev);
      chk(int'(cmd_code) == ec, ddr3_mode ? "R4 code" : "R3 code", cmd_code, ec);
      chk(cmd_addr == ea, "R7 addr", cmd_addr, ea);
      chk(int'(cmd_dll_rst) == ed && int'(cmd_ocd_dflt) == eo, "R8 flags",
          {cmd_dll_rst, cmd_ocd_dflt}, {ed[0], eo[0]});
      chk(done == mdone, "R9 done", done, mdone);
      chk(rfsh_load == (mph == 2), "R9 load", rfsh_load, mph == 2);
      if (mph == 2) chk(rfsh_value == mrf, "R9 value", rfsh_value, mrf);
    end
    // drive inputs for the next edge
    s = start_req || (noise && mph == 1 && qk.size() > 2 && (cyc % 7 == 0));
    start_req = 0;
    case (rpat)
      0: r = 1'b1;
      1: r = (cyc % 3 != 0);
      default: r = (cyc % 5 == 0);
    endcase
    rst = rst_req; start = s; cmd_ready = r;
    // advance the model across that edge
    if (rst_req) begin
      mph = 0; mdone = 0; model_ok = 1;
      qk.delete(); qc.delete(); qd.delete(); qo.delete(); qw.delete(); qa.delete();
    end else if (mph == 1) begin
      if (qk[0] == 0) begin
        if (r) pop();
      end else if (qk[0] == 1) begin
        qw[0] = qw[0] - 1;
        if (qw[0] == 0) pop();
      end else begin
        pop(); mph = 2; mdone = 1; mrf = refresh_val;
      end
    end else if (s) begin
      build(); mph = 1; mdone = 0;
    end else if (mph == 2) begin
      mph = 0;
    end
  end

  task automatic watchdog_hit();
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic run(input bit m, input logic [1:0] c, input logic [1:0] rw,
                     input bit b32, input bit sq, input int rp, input bit nz,
                     input logic [RW-1:0] rv);
    @(posedge clk);
    ddr3_mode = m; col_cfg = c; row_cfg = rw; bus32 = b32; seq_decode = sq;
    refresh_val = rv; rpat = rp; noise = nz; start_req = 1;
    @(posedge clk);
    while (!(mdone && mph == 0)) begin
      @(posedge clk);
      if (cyc > 190000) watchdog_hit();
    end
    noise = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(done == 1'b1 && busy == 1'b0, "R9 done holds", {done, busy}, 2'b10);
    chk(rfsh_value == rv, "R9 value kept", rfsh_value, rv);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !done && !cmd_valid && !rfsh_load, "R1 reset state",
        {busy, done, cmd_valid, rfsh_load}, 0);
    @(posedge clk);
    rst_req = 0;
    repeat (2) @(posedge clk);
    // R3 R5 R7: DDR2, sequential decode, 32-bit bus, stalling ready, start noise
    run(1'b0, 2'd1, 2'd2, 1'b1, 1'b1, 1, 1'b1, 16'h1234);
    // R4 R6: DDR3, interleaved, 16-bit bus, slow ready, start noise
    run(1'b1, 2'd3, 2'd3, 1'b0, 1'b0, 2, 1'b1, 16'h0abc);
    // R2: restart from done, DDR2 with smallest geometry
    run(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 0, 1'b0, 16'h00ff);
    // R7: widest shift, DDR3 sequential 16-bit
    run(1'b1, 2'd3, 2'd3, 1'b0, 1'b1, 1, 1'b0, 16'h5a5a);
    // R1: reset in the middle of a run
    @(posedge clk);
    ddr3_mode = 1'b1; start_req = 1; rpat = 0;
    repeat (30) @(posedge clk);
    rst_req = 1;
    repeat (2) @(posedge clk);
    #1;
    chk(!busy && !done && !cmd_valid, "R1 mid-run reset",
        {busy, done, cmd_valid}, 0);
    @(posedge clk);
    rst_req = 0;
    repeat (5) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule